// File: doc/BRIEF.md
# Memory Pattern Fill and Verify Engine

This engine sweeps a software-chosen window of word addresses on a simple memory command port. In fill mode it writes one fixed data word to every address in the window. The memory port adds valid ECC on its own, so a fill over all populated memory leaves every location correctly encoded. In verify mode it reads every address back and compares each returned word with the same fixed word. Verify mode also reports whether any word differed, the first address that differed, and how many words differed in total.

The data word comes from one of four nibble pairs. In each pair the second nibble is the complement of the first, and the two alternate along the word: 0 with F, A with 5, 3 with C, 6 with 9. A separate zero option forces an all-zero word, which clears the window. Commands are pipelined, with at most `MAX_OUT` responses outstanding. Responses come back in order, and one response is returned for every command, whether it is a read or a write.

The controller is a four-state machine:
- IDLE: waiting for a start request.
- ISSUE: presenting commands.
- DRAIN: waiting for the outstanding responses.
- FINISH: one cycle in which the run is reported complete.

Its transitions are:
- launch: IDLE to ISSUE, on a start with a non-empty window.
- skip: IDLE to FINISH, on a start with end below start.
- last-accept: ISSUE to DRAIN, when the command for the end address is accepted.
- drained: DRAIN to FINISH, when no responses remain outstanding.
- retire: FINISH to IDLE, always.

Top module: `patfill_engine`

## Requirements
- R1: After reset `busy`, `done`, `mem_cmd_valid`, `mismatch` and `fail_count` are all zero.
- R2: A start accepted in IDLE with `cfg_start_addr <= cfg_end_addr` produces exactly one accepted command (`mem_cmd_valid && mem_cmd_ready`) per address, in ascending order from the start address to the end address inclusive. Address and data hold steady while a command waits for ready. The end address may be the top of the address space without wrapping.
- R3: In fill mode (`cfg_verify=0`, `cfg_zero=0`) every command has `mem_cmd_write=1` and carries the selected pattern. Nibble i of the word is the first value of the pair when i is odd and its complement when i is even. `cfg_pat_sel` 0,1,2,3 selects first values 0, A, 3, 6, so the bytes are 0x0F, 0xA5, 0x3C, 0x69.
- R4: With `cfg_zero=1` the word is all zeros, whatever `cfg_pat_sel` holds. This applies to the data written in fill mode and to the expected value in verify mode.
- R5: In verify mode every command has `mem_cmd_write=0`. Each in-order response is compared with the expected word. `mismatch` is set on the first difference, and `first_fail_addr` keeps the address of that response. `fail_count` counts every differing word to the end of the window and saturates at its maximum.
- R6: `busy` is high from the cycle after an accepted start through the cycle in which `done` is high. `done` is a one-cycle pulse after the last response. `busy` is low in the following cycle.
- R7: `cfg_start` is ignored while `busy` is high. The running sweep continues unchanged, and no second sweep follows it.
- R8: A start with `cfg_end_addr < cfg_start_addr` issues no command and still completes with a `done` pulse.
- R9: The number of commands accepted but not yet answered never exceeds `MAX_OUT`.
- R10: `mismatch`, `first_fail_addr` and `fail_count` are cleared by an accepted start and held after `done`. A fill run leaves `mismatch=0` and `fail_count=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Start request, sampled in IDLE |
| cfg_start_addr | input | AW | First word address of the window |
| cfg_end_addr | input | AW | Last word address of the window, inclusive |
| cfg_verify | input | 1 | 1 = verify (read and compare), 0 = fill |
| cfg_zero | input | 1 | Use an all-zero word instead of the pattern |
| cfg_pat_sel | input | 2 | Nibble-pair choice: 0=0/F, 1=A/5, 2=3/C, 3=6/9 |
| mem_cmd_valid | output | 1 | Command present |
| mem_cmd_ready | input | 1 | Memory accepts the command this cycle |
| mem_cmd_write | output | 1 | 1 = write, 0 = read |
| mem_cmd_addr | output | AW | Word address of the command |
| mem_cmd_wdata | output | DW | Write data (the pattern word) |
| mem_rsp_valid | input | 1 | One in-order response (read data or write acknowledge) |
| mem_rsp_rdata | input | DW | Read data of the response |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| mismatch | output | 1 | A verify difference was seen in this run |
| first_fail_addr | output | AW | Address of the first differing word |
| fail_count | output | CW | Number of differing words, saturating |

## Verification
The assertions rely on the memory side behaving well:
- Responses arrive only when a command is still unanswered, in order, and never in the cycle the command is accepted.
- Ready may drop at any time.

The bench memory model meets these conditions by design. It queues each accepted command with a latency of at least one cycle and releases at most one response per cycle, in queue order. Its ready line is random, and in one phase it holds responses long enough to fill the outstanding limit.

// File: rtl/patfill_pkg.sv
package patfill_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_FINISH = 2'd3
    } fill_state_e;

    // First nibble of each selectable pair; the second is its complement.
    function automatic logic [3:0] pair_head(input logic [1:0] sel);
        logic [3:0] n;
        unique case (sel)
            2'd0: n = 4'h0;
            2'd1: n = 4'hA;
            2'd2: n = 4'h3;
            2'd3: n = 4'h6;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/patfill_pat_gen.sv
module patfill_pat_gen
    import patfill_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    sel,
    input  logic          zero,
    output logic [DW-1:0] word
);
    localparam int NIBS = DW / 4;

    logic [3:0] head;
    assign head = pair_head(sel);

    for (genvar i = 0; i < NIBS; i++) begin : g_nib
        if (i % 2 == 1) begin : g_odd
            assign word[i*4 +: 4] = zero ? 4'h0 : head;
        end else begin : g_even
            assign word[i*4 +: 4] = zero ? 4'h0 : ~head;
        end
    end
endmodule

// File: rtl/patfill_addr_ctr.sv
module patfill_addr_ctr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] init,
    input  logic          step,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= init;
        end else if (step) begin
            addr <= addr + AW'(1);
        end
    end
endmodule

// File: rtl/patfill_out_cnt.sv
module patfill_out_cnt #(
    parameter int MAX_OUT = 4,
    localparam int OW = $clog2(MAX_OUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [OW-1:0] cnt
);
    localparam logic [OW-1:0] CAP = OW'(MAX_OUT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   cnt <= cnt + OW'(1);
                2'b01:   cnt <= cnt - OW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // Input assumption: a response only answers an outstanding command (R9)
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt != '0));

    assert_outstanding_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP);
endmodule

// File: rtl/patfill_chk.sv
module patfill_chk #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic [DW-1:0] got,
    input  logic [DW-1:0] want,
    input  logic [AW-1:0] at,
    output logic          mismatch,
    output logic [AW-1:0] first_addr,
    output logic [CW-1:0] count
);
    logic differs;
    assign differs = en && (got != want);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            mismatch   <= 1'b0;
            first_addr <= '0;
            count      <= '0;
        end else if (differs) begin
            if (!mismatch) begin
                first_addr <= at;
            end
            mismatch <= 1'b1;
            if (count != '1) begin
                count <= count + CW'(1);
            end
        end
    end

    // R5: once recorded, the first failing address is frozen until a new run
    assert_first_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && !clear) |=> $stable(first_addr));

    // R5: the count never falls within a run
    assert_count_mono_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (count >= $past(count)));
endmodule

// File: rtl/patfill_engine.sv
module patfill_engine
    import patfill_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int MAX_OUT = 4,
    parameter int CW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_start,
    input  logic [AW-1:0] cfg_start_addr,
    input  logic [AW-1:0] cfg_end_addr,
    input  logic          cfg_verify,
    input  logic          cfg_zero,
    input  logic [1:0]    cfg_pat_sel,
    output logic          mem_cmd_valid,
    input  logic          mem_cmd_ready,
    output logic          mem_cmd_write,
    output logic [AW-1:0] mem_cmd_addr,
    output logic [DW-1:0] mem_cmd_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_rdata,
    output logic          busy,
    output logic          done,
    output logic          mismatch,
    output logic [AW-1:0] first_fail_addr,
    output logic [CW-1:0] fail_count
);
    localparam int OW = $clog2(MAX_OUT + 1);
    localparam logic [OW-1:0] CAP = OW'(MAX_OUT);

    fill_state_e state_q, state_d;

    logic [AW-1:0] end_q;
    logic          verify_q;
    logic          zero_q;
    logic [1:0]    sel_q;

    logic          launch;
    logic          empty_win;
    logic          accept;
    logic          last_cmd;
    logic [OW-1:0] pending;
    logic          room;
    logic [AW-1:0] rsp_addr;
    logic [DW-1:0] pat_word;

    assign launch    = (state_q == ST_IDLE) && cfg_start;
    assign empty_win = cfg_end_addr < cfg_start_addr;
    assign accept    = mem_cmd_valid && mem_cmd_ready;
    assign last_cmd  = (mem_cmd_addr == end_q);
    assign room      = pending < CAP;

    // Run configuration is captured only when a start is taken in IDLE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_q    <= '0;
            verify_q <= 1'b0;
            zero_q   <= 1'b0;
            sel_q    <= '0;
        end else if (launch) begin
            end_q    <= cfg_end_addr;
            verify_q <= cfg_verify;
            zero_q   <= cfg_zero;
            sel_q    <= cfg_pat_sel;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_start) begin
                    state_d = empty_win ? ST_FINISH : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (accept && last_cmd) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (pending == '0) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        mem_cmd_valid = 1'b0;
        busy          = 1'b1;
        done          = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy          = 1'b0;
            ST_ISSUE:  mem_cmd_valid = room;
            ST_DRAIN:  ;
            ST_FINISH: done          = 1'b1;
        endcase
    end

    assign mem_cmd_write = !verify_q;
    assign mem_cmd_wdata = pat_word;

    patfill_addr_ctr #(.AW(AW)) u_cmd_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (launch),
        .init  (cfg_start_addr),
        .step  (accept),
        .addr  (mem_cmd_addr)
    );

    patfill_addr_ctr #(.AW(AW)) u_rsp_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (launch),
        .init  (cfg_start_addr),
        .step  (mem_rsp_valid),
        .addr  (rsp_addr)
    );

    patfill_out_cnt #(.MAX_OUT(MAX_OUT)) u_pending (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (accept),
        .dec   (mem_rsp_valid),
        .cnt   (pending)
    );

    patfill_pat_gen #(.DW(DW)) u_pat (
        .sel   (sel_q),
        .zero  (zero_q),
        .word  (pat_word)
    );

    patfill_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (launch),
        .en         (mem_rsp_valid && verify_q && busy),
        .got        (mem_rsp_rdata),
        .want       (pat_word),
        .at         (rsp_addr),
        .mismatch   (mismatch),
        .first_addr (first_fail_addr),
        .count      (fail_count)
    );

    // R2: a waiting command keeps its address and data
    assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && !mem_cmd_ready) |=>
            (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_wdata)));

    // R2: no command ever targets an address beyond the window end
    assert_addr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |-> (mem_cmd_addr <= end_q));

    // R6: done lasts one cycle and is followed by idle
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R7: a start while busy leaves the captured run settings alone
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_start) |=> ($stable(end_q) && $stable(verify_q)
                                  && $stable(zero_q) && $stable(sel_q)));
endmodule

// File: tb/patfill_engine_tb_top.sv
module patfill_engine_tb_top;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int MO = 4;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_start = 1'b0;
    logic [AW-1:0] cfg_start_addr = '0;
    logic [AW-1:0] cfg_end_addr = '0;
    logic          cfg_verify = 1'b0;
    logic          cfg_zero = 1'b0;
    logic [1:0]    cfg_pat_sel = '0;
    logic          mem_cmd_valid;
    logic          mem_cmd_ready = 1'b0;
    logic          mem_cmd_write;
    logic [AW-1:0] mem_cmd_addr;
    logic [DW-1:0] mem_cmd_wdata;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_rdata = '0;
    logic          busy;
    logic          done;
    logic          mismatch;
    logic [AW-1:0] first_fail_addr;
    logic [CW-1:0] fail_count;

    always #10 clk = ~clk;   // 50 MHz

    patfill_engine #(.AW(AW), .DW(DW), .MAX_OUT(MO), .CW(CW)) dut_i (.*);

    int n_vec = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ref_word(input logic [1:0] sel, input bit zero);
        logic [7:0] b;
        case (sel)
            2'd0:    b = 8'h0F;
            2'd1:    b = 8'hA5;
            2'd2:    b = 8'h3C;
            default: b = 8'h69;
        endcase
        return zero ? '0 : {(DW/8){b}};
    endfunction

    typedef struct {
        logic [AW-1:0] a;
        logic          w;
        logic [DW-1:0] d;
    } cmd_t;

    typedef struct {
        int            due;
        logic [DW-1:0] d;
    } rsp_t;

    cmd_t          expq[$];
    rsp_t          pend[$];
    logic [DW-1:0] mem [int];
    string         tag = "R2";
    bit            slow = 1'b0;
    int            cyc = 0;

    // Memory model and per-command comparison, all at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            mem_cmd_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            pend.delete();
        end else begin
            if (pend.size() > 0 && pend[0].due <= cyc) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = pend[0].d;
                void'(pend.pop_front());
            end else begin
                mem_rsp_valid = 1'b0;
                mem_rsp_rdata = '0;
            end
            mem_cmd_ready = ($urandom_range(0, 3) != 0);
            if (mem_cmd_valid && mem_cmd_ready) begin
                int   outst;
                int   due;
                rsp_t r;
                outst = pend.size() + (mem_rsp_valid ? 1 : 0);
                check(outst < MO, "R9", "outstanding before accept", outst, MO - 1);
                if (expq.size() == 0) begin
                    check(1'b0, "R2", "unexpected command addr", mem_cmd_addr, 0);
                end else begin
                    cmd_t e;
                    e = expq.pop_front();
                    check(mem_cmd_addr == e.a, "R2", "command address", mem_cmd_addr, e.a);
                    check(mem_cmd_write == e.w, tag, "command direction", mem_cmd_write, e.w);
                    if (e.w) begin
                        check(mem_cmd_wdata == e.d, tag, "write data", mem_cmd_wdata, e.d);
                    end
                end
                if (mem_cmd_write) begin
                    mem[int'(mem_cmd_addr)] = mem_cmd_wdata;
                end
                due = cyc + (slow ? int'($urandom_range(4, 9)) : int'($urandom_range(1, 3)));
                if (pend.size() > 0 && pend[pend.size()-1].due > due) begin
                    due = pend[pend.size()-1].due;
                end
                r.due = due;
                r.d   = mem_cmd_write ? '0 :
                        (mem.exists(int'(mem_cmd_addr)) ? mem[int'(mem_cmd_addr)] : '0);
                pend.push_back(r);
            end
        end
    end

    bit            exp_mis;
    logic [AW-1:0] exp_first;
    int            exp_cnt;

    task automatic launch(input logic [AW-1:0] s, input logic [AW-1:0] e,
                          input bit verify, input bit zero, input logic [1:0] sel);
        logic [DW-1:0] w;
        w = ref_word(sel, zero);
        exp_mis = 1'b0;
        exp_first = '0;
        exp_cnt = 0;
        if (s <= e) begin
            for (int a = int'(s); a <= int'(e); a++) begin
                cmd_t c;
                logic [DW-1:0] cur;
                c.a = AW'(a);
                c.w = !verify;
                c.d = w;
                expq.push_back(c);
                if (verify) begin
                    cur = mem.exists(a) ? mem[a] : '0;
                    if (cur != w) begin
                        if (!exp_mis) exp_first = AW'(a);
                        exp_mis = 1'b1;
                        exp_cnt++;
                    end
                end
            end
        end
        @(negedge clk);
        cfg_start_addr = s;
        cfg_end_addr   = e;
        cfg_verify     = verify;
        cfg_zero       = zero;
        cfg_pat_sel    = sel;
        cfg_start      = 1'b1;
        @(negedge clk);
        cfg_start      = 1'b0;
    endtask

    task automatic finish(input string rtag);
        int guard;
        guard = 0;
        while (!done && guard < 5000) begin
            check(busy == 1'b1, "R6", "busy during run", busy, 1);
            @(negedge clk);
            guard++;
        end
        check(done == 1'b1, "R6", "done reached", done, 1);
        check(busy == 1'b1, "R6", "busy with done", busy, 1);
        check(expq.size() == 0, "R2", "commands left unissued", expq.size(), 0);
        check(mismatch == exp_mis, rtag, "mismatch flag", mismatch, exp_mis);
        check(fail_count == CW'(exp_cnt), rtag, "fail count", fail_count, exp_cnt);
        if (exp_mis) begin
            check(first_fail_addr == exp_first, rtag, "first fail address",
                  first_fail_addr, exp_first);
        end
        @(negedge clk);
        check(!busy && !done, "R6", "idle after done", {busy, done}, 0);
        check(mismatch == exp_mis && fail_count == CW'(exp_cnt), "R10",
              "results held after done", fail_count, exp_cnt);
        expq.delete();
    endtask

    task automatic run(input logic [AW-1:0] s, input logic [AW-1:0] e,
                       input bit verify, input bit zero, input logic [1:0] sel,
                       input string rtag);
        tag = rtag;
        launch(s, e, verify, zero, sel);
        finish(verify ? "R5" : "R10");
    endtask

    // Watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <150000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy && !done && !mem_cmd_valid, "R1", "control outputs",
              {busy, done, mem_cmd_valid}, 0);
        check(!mismatch && fail_count == '0, "R1", "result outputs", fail_count, 0);

        // R3: each pattern selection, then read back (R5)
        run(16'h0010, 16'h002F, 1'b0, 1'b0, 2'd0, "R3");
        run(16'h0010, 16'h002F, 1'b1, 1'b0, 2'd0, "R5");
        slow = 1'b1;   // R9: long latencies fill the outstanding limit
        run(16'h0100, 16'h013F, 1'b0, 1'b0, 2'd1, "R3");
        run(16'h0100, 16'h013F, 1'b1, 1'b0, 2'd1, "R9");
        slow = 1'b0;
        run(16'h0200, 16'h0207, 1'b0, 1'b0, 2'd2, "R3");
        run(16'h0300, 16'h0307, 1'b0, 1'b0, 2'd3, "R3");
        run(16'h0300, 16'h0307, 1'b1, 1'b0, 2'd3, "R5");

        // R4: zero option over the first region, with a non-zero selection
        run(16'h0010, 16'h001F, 1'b0, 1'b1, 2'd2, "R4");
        run(16'h0010, 16'h001F, 1'b1, 1'b1, 2'd1, "R4");
        // R5: every zeroed word differs from the 0/F pattern
        run(16'h0010, 16'h001F, 1'b1, 1'b0, 2'd0, "R5");

        // R5: two corrupted words, first address and count
        mem[16'h0105] = 32'hDEAD0001;
        mem[16'h0120] = 32'h00000000;
        run(16'h0100, 16'h013F, 1'b1, 1'b0, 2'd1, "R5");

        // R10: a fill run clears the previous results
        run(16'h0400, 16'h0403, 1'b0, 1'b0, 2'd0, "R10");

        // R2: single-word window and a window ending at the top address
        run(16'h0500, 16'h0500, 1'b0, 1'b0, 2'd1, "R2");
        run(16'hFFFD, 16'hFFFF, 1'b0, 1'b0, 2'd2, "R2");
        run(16'hFFFD, 16'hFFFF, 1'b1, 1'b0, 2'd2, "R5");

        // R8: end below start
        tag = "R8";
        launch(16'h0600, 16'h05FF, 1'b0, 1'b0, 2'd0);
        finish("R8");
        check(expq.size() == 0, "R8", "no command issued", expq.size(), 0);

        // R7: start while busy is ignored
        tag = "R7";
        launch(16'h0700, 16'h071F, 1'b0, 1'b0, 2'd3);
        repeat (3) begin
            check(busy == 1'b1, "R6", "busy during run", busy, 1);
            @(negedge clk);
        end
        cfg_start_addr = 16'h0800;
        cfg_end_addr   = 16'h0810;
        cfg_verify     = 1'b1;
        cfg_zero       = 1'b1;
        cfg_pat_sel    = 2'd0;
        cfg_start      = 1'b1;
        @(negedge clk);
        cfg_start      = 1'b0;
        finish("R10");
        for (int k = 0; k < 12; k++) begin
            check(!busy && !mem_cmd_valid, "R7", "no second sweep",
                  {busy, mem_cmd_valid}, 0);
            @(negedge clk);
        end
        check(mem[16'h0700] == ref_word(2'd3, 1'b0), "R7", "original pattern kept",
              mem[16'h0700], ref_word(2'd3, 1'b0));
        check(!mem.exists(16'h0800), "R7", "ignored window untouched",
              mem.exists(16'h0800), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule